// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor port and carries one coprocessor instruction from issue to completion. It handles five instruction kinds: a word burst from memory into the coprocessor, a word burst from the coprocessor out to memory, a register move into the coprocessor, a register move back to the core, and an internal data operation. After a start strobe it checks permissions and the target address. It then opens the exchange with an opening request and keeps asking while the coprocessor reports busy. During that wait it may give up if an interrupt is pending. For bursts it steps through memory one word per cycle.

The coprocessor answers each request in the same cycle with a two-bit code. The memory answers in the same cycle as well. The sequencer ends every instruction with a one-cycle completion pulse and an outcome code. When an interrupt caused the instruction to be dropped, it also reports which interrupt source won. Neither the coprocessor nor the memory is part of this block.

Top module: `cp_hs_seq`

## Requirements
- R1: If the bit of `cp_allow_i` indexed by the coprocessor number is 0, no coprocessor request is issued, and the cycle after the check ends with outcome UNDEF (1).
- R2: A load whose address has any bit at or above bit 26 set is rejected with outcome ABORT (2) and no request. A store is rejected the same way for that case, and also when its address is below 32 (the vector area). A load below 32 is accepted.
- R3: The first request of every accepted instruction uses phase FIRST (0). Each cycle that follows a BUSY (1) answer is a wait cycle. In a wait cycle `idle_cyc_o` is high and a request with phase BUSY (1) is issued, unless an interrupt is pending.
- R4: An interrupt that is pending in a wait cycle turns that cycle's request into phase INTR (2). The next cycle ends the instruction with outcome INTR (3). An interrupt has no effect on an instruction that never waits.
- R5: Pending interrupts are ranked as follows: reset line low first (kind 1), then fast interrupt low with its mask clear (kind 2), then normal interrupt low with its mask clear (kind 3). A masked source is not pending. The winning kind is shown on `int_kind_o` with the completion pulse.
- R6: A CANT (2) answer to a FIRST or BUSY request ends a load or store with ABORT (2). It ends a register move or data operation with UNDEF (1).
- R7: A burst issues phase DATA (3) requests, one word per cycle. The first word is at the instruction address. Each INC (3) answer advances the address by 4 and adds one more word. Any other answer ends the burst. A load passes `mem_rdata_i` to `cp_wdata_o`. A store raises `mem_we_o` and passes `cp_rdata_i` to `mem_wdata_o`.
- R8: When `wb_i` was set at start, `wb_o` pulses on the first burst cycle only.
- R9: A `mem_abort_i` on any burst word does not stop the burst, but the instruction then ends with ABORT (2).
- R10: A move to the core that gets a CANT answer returns 0xF000_0000 on `result_o`.
- R11: An accepted register move takes one coprocessor cycle (`cp_cyc_o`) before completion. A move to the core adds one more cycle with `idle_cyc_o` high and returns the `cp_rdata_i` value that came with the accepting answer.
- R12: `done_o` is a single-cycle pulse. Outcome codes are OK 0, UNDEF 1, ABORT 2, INTR 3. Op codes are load 0, store 1, move-to-coprocessor 2, move-to-core 3, data op 4. Answer codes are READY 0, BUSY 1, CANT 2, INC 3. After reset, no request, memory access or completion is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken in idle |
| op_i | input | 3 | Instruction kind |
| cp_num_i | input | 4 | Coprocessor number |
| addr_i | input | 32 | Burst start address |
| wb_i | input | 1 | Base writeback requested |
| core_data_i | input | 32 | Value for a move into the coprocessor |
| cp_allow_i | input | 16 | Per-coprocessor access permission |
| reset_line_ni | input | 1 | Core reset request, active low |
| fiq_ni | input | 1 | Fast interrupt, active low |
| irq_ni | input | 1 | Normal interrupt, active low |
| fiq_mask_i | input | 1 | Fast interrupt mask |
| irq_mask_i | input | 1 | Normal interrupt mask |
| cp_req_o | output | 1 | Coprocessor request valid |
| cp_phase_o | output | 2 | Request phase |
| cp_op_o | output | 3 | Instruction kind to the coprocessor |
| cp_num_o | output | 4 | Addressed coprocessor |
| cp_wdata_o | output | 32 | Data to the coprocessor |
| cp_resp_i | input | 2 | Coprocessor answer |
| cp_rdata_i | input | 32 | Data from the coprocessor |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_abort_i | input | 1 | Memory access aborted |
| wb_o | output | 1 | Apply base writeback |
| idle_cyc_o | output | 1 | Internal cycle spent |
| cp_cyc_o | output | 1 | Coprocessor cycle spent |
| done_o | output | 1 | Completion pulse |
| outcome_o | output | 2 | Completion outcome |
| int_kind_o | output | 2 | Interrupt that caused abandonment |
| result_o | output | 32 | Value for a move to the core |

## Verification
Each instruction kind is first run with an immediate accept. It is then run with a few busy answers, which shows that the wait loop counts exactly one idle cycle per busy answer. Interrupt lines are set in several mixes: masked, single, competing, and with the reset line low. These mixes separate a correct priority order from a wrong one. They also separate "interrupt ignored because no wait happened" from "interrupt taken". Bursts of one, three and four words, with and without writeback and with an abort on a middle word, check the address stepping. They also check the direction of data and that an abort is sticky without cutting the burst short. Refused moves, refused bursts, denied coprocessor numbers and bad or vector-area addresses check that every trap class reports its own outcome.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_TO_CP = 3'd2, OP_FROM_CP = 3'd3, OP_DATA = 3'd4
  } cp_op_e;

  typedef enum logic [1:0] {RSP_READY = 2'd0, RSP_BUSY = 2'd1, RSP_CANT = 2'd2, RSP_INC = 2'd3} cp_rsp_e;
  typedef enum logic [1:0] {PH_FIRST = 2'd0, PH_BUSY = 2'd1, PH_INTR = 2'd2, PH_DATA = 2'd3} cp_ph_e;
  typedef enum logic [1:0] {OC_OK = 2'd0, OC_UNDEF = 2'd1, OC_ABORT = 2'd2, OC_INTR = 2'd3} oc_e;
  typedef enum logic [1:0] {IK_NONE = 2'd0, IK_RESET = 2'd1, IK_FIQ = 2'd2, IK_IRQ = 2'd3} ik_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FIRST, S_BUSY, S_XFER, S_CCYC, S_ICYC, S_DONE, S_TRAP
  } st_e;

  function automatic logic op_is_mem(logic [2:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic op_is_move(logic [2:0] op);
    return (op == OP_TO_CP) || (op == OP_FROM_CP);
  endfunction
endpackage

// File: rtl/cp_int_pri.sv
module cp_int_pri
  import cp_seq_pkg::*;
(
  input  logic       reset_line_ni,
  input  logic       fiq_ni,
  input  logic       irq_ni,
  input  logic       fiq_mask_i,
  input  logic       irq_mask_i,
  output logic       pend_o,
  output logic [1:0] kind_o
);
  logic fiq_live, irq_live;

  assign fiq_live = !fiq_ni && !fiq_mask_i;
  assign irq_live = !irq_ni && !irq_mask_i;

  always_comb begin
    kind_o = IK_NONE;
    if (!reset_line_ni)  kind_o = IK_RESET;
    else if (fiq_live)   kind_o = IK_FIQ;
    else if (irq_live)   kind_o = IK_IRQ;
  end

  assign pend_o = !reset_line_ni || fiq_live || irq_live;

  // R5: a masked normal interrupt alone never wins
  always_comb begin
    if (reset_line_ni && fiq_ni && irq_mask_i)
      a_masked_r5: assert (!pend_o);
  end
endmodule

// File: rtl/cp_addr_chk.sv
module cp_addr_chk #(
  parameter int AW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_mem_i,
  input  logic          is_store_i,
  output logic          bad_o
);
  logic out_of_range;
  logic in_vec;

  generate
    if (LEGAL_BITS < AW) begin : g_range
      assign out_of_range = |addr_i[AW-1:LEGAL_BITS];
    end else begin : g_norange
      assign out_of_range = 1'b0;
    end
  endgenerate

  assign in_vec = addr_i < AW'(VEC_BYTES);
  assign bad_o  = is_mem_i && (out_of_range || (is_store_i && in_vec));
endmodule

// File: rtl/cp_burst_ctr.sv
module cp_burst_ctr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          xfer_i,
  input  logic          step_i,
  input  logic          mem_abort_i,
  output logic [AW-1:0] addr_o,
  output logic          first_o,
  output logic          abort_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      first_o <= 1'b0;
      abort_o <= 1'b0;
    end else if (load_i) begin
      addr_o  <= base_i;
      first_o <= 1'b1;
      abort_o <= 1'b0;
    end else if (xfer_i) begin
      first_o <= 1'b0;
      if (mem_abort_i) abort_o <= 1'b1;
      if (step_i)      addr_o  <= addr_o + STEP;
    end
  end

  // R7: each increment answer moves the word address by one word
  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + STEP));

  // R9: abort stays set until the next instruction
  p_abort_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !load_i) |=> abort_o);
endmodule

// File: rtl/cp_hs_seq.sv
module cp_hs_seq
  import cp_seq_pkg::*;
#(
  parameter int NCP        = 16,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32,
  localparam int CPN_W     = $clog2(NCP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [CPN_W-1:0] cp_num_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wb_i,
  input  logic [DW-1:0]    core_data_i,
  input  logic [NCP-1:0]   cp_allow_i,
  input  logic             reset_line_ni,
  input  logic             fiq_ni,
  input  logic             irq_ni,
  input  logic             fiq_mask_i,
  input  logic             irq_mask_i,
  output logic             cp_req_o,
  output logic [1:0]       cp_phase_o,
  output logic [2:0]       cp_op_o,
  output logic [CPN_W-1:0] cp_num_o,
  output logic [DW-1:0]    cp_wdata_o,
  input  logic [1:0]       cp_resp_i,
  input  logic [DW-1:0]    cp_rdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_abort_i,
  output logic             wb_o,
  output logic             idle_cyc_o,
  output logic             cp_cyc_o,
  output logic             done_o,
  output logic [1:0]       outcome_o,
  output logic [1:0]       int_kind_o,
  output logic [DW-1:0]    result_o
);
  localparam logic [DW-1:0] REFUSED_VAL = {4'hF, {(DW-4){1'b0}}};

  st_e              st_q, st_d;
  logic [2:0]       op_q;
  logic [CPN_W-1:0] cpn_q;
  logic             wb_q;
  logic [DW-1:0]    core_q;
  logic [1:0]       oc_q, oc_d;
  logic [1:0]       kind_q, kind_d;
  logic [DW-1:0]    res_q, res_d;

  logic             is_mem, is_store, is_move, is_from;
  logic             addr_bad, pend;
  logic [1:0]       pend_kind;
  logic             burst_first, burst_abort;
  logic             take_ans;
  logic             step;
  cp_rsp_e          rsp;

  assign rsp      = cp_rsp_e'(cp_resp_i);
  assign is_mem   = op_is_mem(op_q);
  assign is_store = op_q == OP_STORE;
  assign is_move  = op_is_move(op_q);
  assign is_from  = op_q == OP_FROM_CP;

  cp_int_pri u_pri (
    .reset_line_ni (reset_line_ni),
    .fiq_ni        (fiq_ni),
    .irq_ni        (irq_ni),
    .fiq_mask_i    (fiq_mask_i),
    .irq_mask_i    (irq_mask_i),
    .pend_o        (pend),
    .kind_o        (pend_kind)
  );

  cp_addr_chk #(.AW(AW), .LEGAL_BITS(LEGAL_BITS), .VEC_BYTES(VEC_BYTES)) u_chk (
    .addr_i     (mem_addr_o),
    .is_mem_i   (is_mem),
    .is_store_i (is_store),
    .bad_o      (addr_bad)
  );

  assign step = (st_q == S_XFER) && (rsp == RSP_INC);

  cp_burst_ctr #(.AW(AW)) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      ((st_q == S_IDLE) && start_i),
    .base_i      (addr_i),
    .xfer_i      (st_q == S_XFER),
    .step_i      (step),
    .mem_abort_i (mem_abort_i),
    .addr_o      (mem_addr_o),
    .first_o     (burst_first),
    .abort_o     (burst_abort)
  );

  always_comb begin
    st_d       = st_q;
    oc_d       = oc_q;
    kind_d     = kind_q;
    res_d      = res_q;
    take_ans   = 1'b0;
    cp_req_o   = 1'b0;
    cp_phase_o = PH_FIRST;
    idle_cyc_o = 1'b0;
    cp_cyc_o   = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d   = S_CHECK;
        oc_d   = OC_OK;
        kind_d = IK_NONE;
        res_d  = '0;
      end
      S_CHECK: begin
        if (!cp_allow_i[cpn_q]) begin
          st_d = S_TRAP;
          oc_d = OC_UNDEF;
        end else if (addr_bad) begin
          st_d = S_TRAP;
          oc_d = OC_ABORT;
        end else begin
          st_d = S_FIRST;
        end
      end
      S_FIRST: begin
        cp_req_o = 1'b1;
        take_ans = 1'b1;
      end
      S_BUSY: begin
        idle_cyc_o = 1'b1;
        cp_req_o   = 1'b1;
        if (pend) begin
          cp_phase_o = PH_INTR;
          kind_d     = pend_kind;
          oc_d       = OC_INTR;
          st_d       = S_TRAP;
        end else begin
          cp_phase_o = PH_BUSY;
          take_ans   = 1'b1;
        end
      end
      S_XFER: begin
        cp_req_o   = 1'b1;
        cp_phase_o = PH_DATA;
        if (rsp != RSP_INC) st_d = S_DONE;
      end
      S_CCYC: begin
        cp_cyc_o = 1'b1;
        st_d     = is_from ? S_ICYC : S_DONE;
      end
      S_ICYC: begin
        idle_cyc_o = 1'b1;
        st_d       = S_DONE;
      end
      S_DONE, S_TRAP: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase

    // answer to an opening or a repeated request
    if (take_ans) begin
      unique case (rsp)
        RSP_BUSY: st_d = S_BUSY;
        RSP_CANT: begin
          st_d = S_TRAP;
          oc_d = is_mem ? OC_ABORT : OC_UNDEF;
          if (is_from) res_d = REFUSED_VAL;
        end
        default: begin
          if (is_mem)       st_d = S_XFER;
          else if (is_move) st_d = S_CCYC;
          else              st_d = S_DONE;
          if (is_from) res_d = cp_rdata_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_DATA;
      cpn_q  <= '0;
      wb_q   <= 1'b0;
      core_q <= '0;
      oc_q   <= OC_OK;
      kind_q <= IK_NONE;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      oc_q   <= oc_d;
      kind_q <= kind_d;
      res_q  <= res_d;
      if (st_q == S_IDLE && start_i) begin
        op_q   <= op_i;
        cpn_q  <= cp_num_i;
        wb_q   <= wb_i;
        core_q <= core_data_i;
      end
    end
  end

  assign cp_op_o     = op_q;
  assign cp_num_o    = cpn_q;
  assign cp_wdata_o  = (st_q == S_XFER && !is_store) ? mem_rdata_i : core_q;
  assign mem_req_o   = st_q == S_XFER;
  assign mem_we_o    = mem_req_o && is_store;
  assign mem_wdata_o = cp_rdata_i;
  assign wb_o        = mem_req_o && burst_first && wb_q;
  assign done_o      = (st_q == S_DONE) || (st_q == S_TRAP);
  assign outcome_o   = (st_q == S_TRAP) ? oc_q : (burst_abort ? OC_ABORT : OC_OK);
  assign int_kind_o  = kind_q;
  assign result_o    = res_q;

  // R1: a denied coprocessor never sees a request
  p_deny_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_CHECK && !cp_allow_i[cpn_q]) |=> (!cp_req_o && done_o && outcome_o == OC_UNDEF));

  // R3: a busy-phase request always comes with an idle cycle
  p_busy_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_o && cp_phase_o == PH_BUSY) |-> idle_cyc_o);

  // R4: an interrupt request is followed by the interrupted outcome
  p_intr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_o && cp_phase_o == PH_INTR) |=> (done_o && outcome_o == OC_INTR));

  // R6: a refused opening or repeated request ends with a trap outcome
  p_cant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_o && (cp_phase_o == PH_FIRST || cp_phase_o == PH_BUSY) && cp_resp_i == RSP_CANT)
      |=> (done_o && outcome_o != OC_OK));

  // R8: writeback only alongside a memory word
  p_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (mem_req_o && !$past(mem_req_o)));

  // R11: one coprocessor cycle per move
  p_ccyc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_cyc_o |=> !cp_cyc_o);

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_cp_hs_seq.sv
`timescale 1ns/1ps
module tb_cp_hs_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd4;
  logic [3:0]  cp_num_i = '0;
  logic [31:0] addr_i = '0;
  logic        wb_i = 1'b0;
  logic [31:0] core_data_i = '0;
  logic [15:0] cp_allow_i = 16'hFFFF;
  logic        reset_line_ni = 1'b1, fiq_ni = 1'b1, irq_ni = 1'b1;
  logic        fiq_mask_i = 1'b0, irq_mask_i = 1'b0;
  logic        cp_req_o;
  logic [1:0]  cp_phase_o;
  logic [2:0]  cp_op_o;
  logic [3:0]  cp_num_o;
  logic [31:0] cp_wdata_o;
  logic [1:0]  cp_resp_i;
  logic [31:0] cp_rdata_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_abort_i;
  logic        wb_o, idle_cyc_o, cp_cyc_o, done_o;
  logic [1:0]  outcome_o, int_kind_o;
  logic [31:0] result_o;

  localparam logic [31:0] MEM_KEY = 32'h5A00_00C3;

  int          n_chk = 0, n_fail = 0;
  int          busy_n = 0, inc_n = 0;
  logic [1:0]  final_rsp = 2'd0;
  logic [31:0] abort_addr = 32'hFFFF_FFFF;
  int          bsy_seen, inc_seen;

  always #2 clk_i = ~clk_i;

  cp_hs_seq dut (.*);

  // coprocessor and memory models
  assign mem_rdata_i = mem_addr_o ^ MEM_KEY;
  assign mem_abort_i = mem_req_o && (mem_addr_o == abort_addr);

  always_comb begin
    cp_resp_i = 2'd0;
    if (cp_req_o && (cp_phase_o == 2'd0 || cp_phase_o == 2'd1))
      cp_resp_i = (bsy_seen < busy_n) ? 2'd1 : final_rsp;
    else if (cp_req_o && cp_phase_o == 2'd3)
      cp_resp_i = (inc_seen < inc_n) ? 2'd3 : 2'd0;
  end

  always @(posedge clk_i) begin
    if (start_i) begin
      bsy_seen <= 0;
      inc_seen <= 0;
    end else if (cp_req_o) begin
      if ((cp_phase_o == 2'd0 || cp_phase_o == 2'd1) && bsy_seen < busy_n) bsy_seen <= bsy_seen + 1;
      if (cp_phase_o == 2'd3 && inc_seen < inc_n) inc_seen <= inc_seen + 1;
    end
  end

  typedef struct {
    bit        req;  bit [1:0] ph;
    bit        mreq; bit mwe; bit [31:0] maddr;
    bit [1:0]  xsel; bit [31:0] xdata;
    bit        done; bit [1:0] oc; bit [1:0] kind;
    bit        icyc; bit ccyc; bit wb;
    bit        chk_res; bit [31:0] res;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(input exp_t e, input string tag);
    chk(cp_req_o == e.req, tag, "cp_req", 32'(cp_req_o), 32'(e.req));
    if (e.req) chk(cp_phase_o == e.ph, tag, "phase", 32'(cp_phase_o), 32'(e.ph));
    chk(mem_req_o == e.mreq, tag, "mem_req", 32'(mem_req_o), 32'(e.mreq));
    if (e.mreq) begin
      chk(mem_we_o == e.mwe, tag, "mem_we", 32'(mem_we_o), 32'(e.mwe));
      chk(mem_addr_o == e.maddr, tag, "mem_addr", mem_addr_o, e.maddr);
    end
    if (e.xsel == 2'd1) chk(cp_wdata_o == e.xdata, tag, "cp_wdata", cp_wdata_o, e.xdata);
    if (e.xsel == 2'd2) chk(mem_wdata_o == e.xdata, tag, "mem_wdata", mem_wdata_o, e.xdata);
    chk(done_o == e.done, tag, "done", 32'(done_o), 32'(e.done));
    if (e.done) begin
      chk(outcome_o == e.oc, tag, "outcome", 32'(outcome_o), 32'(e.oc));
      chk(int_kind_o == e.kind, tag, "int_kind", 32'(int_kind_o), 32'(e.kind));
    end
    if (e.chk_res) chk(result_o == e.res, tag, "result", result_o, e.res);
    chk(idle_cyc_o == e.icyc, tag, "idle_cyc", 32'(idle_cyc_o), 32'(e.icyc));
    chk(cp_cyc_o == e.ccyc, tag, "cp_cyc", 32'(cp_cyc_o), 32'(e.ccyc));
    chk(wb_o == e.wb, tag, "wb", 32'(wb_o), 32'(e.wb));
  endtask

  function automatic bit [1:0] exp_kind();
    if (!reset_line_ni) return 2'd1;
    if (!fiq_ni && !fiq_mask_i) return 2'd2;
    if (!irq_ni && !irq_mask_i) return 2'd3;
    return 2'd0;
  endfunction

  task automatic run(input string tag, input bit [2:0] op, input bit [3:0] cpn,
                     input bit [31:0] addr, input bit wb, input int nb,
                     input bit [1:0] fin, input int ni, input bit [31:0] cdat);
    exp_t e;
    bit ls, bad, intr, ab;
    bit [1:0] k;
    ls = (op == 3'd0) || (op == 3'd1);
    bad = ls && ((addr[31:26] != 0) || (op == 3'd1 && addr < 32));
    k = exp_kind();
    q.delete();
    e = '{default: '0};
    q.push_back(e);
    if (!cp_allow_i[cpn]) begin
      e.done = 1; e.oc = 2'd1; q.push_back(e);
    end else if (bad) begin
      e.done = 1; e.oc = 2'd2; q.push_back(e);
    end else begin
      e.req = 1; e.ph = 2'd0;
      if (op == 3'd2) begin e.xsel = 2'd1; e.xdata = 32'h1357_9BDF; end
      q.push_back(e);
      intr = 0;
      for (int i = 1; i <= nb; i++) begin
        e = '{default: '0};
        e.icyc = 1; e.req = 1;
        if (k != 0) begin
          e.ph = 2'd2; q.push_back(e);
          e = '{default: '0}; e.done = 1; e.oc = 2'd3; e.kind = k; q.push_back(e);
          intr = 1;
          break;
        end
        e.ph = 2'd1; q.push_back(e);
      end
      if (!intr) begin
        e = '{default: '0};
        if (fin == 2'd2) begin
          e.done = 1; e.oc = ls ? 2'd2 : 2'd1;
          if (op == 3'd3) begin e.chk_res = 1; e.res = 32'hF000_0000; end
          q.push_back(e);
        end else if (ls) begin
          ab = 0;
          for (int j = 0; j <= ni; j++) begin
            e = '{default: '0};
            e.req = 1; e.ph = 2'd3; e.mreq = 1; e.mwe = (op == 3'd1);
            e.maddr = addr + 32'(4 * j); e.wb = wb && (j == 0);
            e.xsel = (op == 3'd1) ? 2'd2 : 2'd1;
            e.xdata = (op == 3'd1) ? cdat : (e.maddr ^ MEM_KEY);
            if (e.maddr == abort_addr) ab = 1;
            q.push_back(e);
          end
          e = '{default: '0}; e.done = 1; e.oc = ab ? 2'd2 : 2'd0; q.push_back(e);
        end else if (op == 3'd2 || op == 3'd3) begin
          e.ccyc = 1; q.push_back(e);
          if (op == 3'd3) begin e = '{default: '0}; e.icyc = 1; q.push_back(e); end
          e = '{default: '0}; e.done = 1; e.oc = 2'd0;
          if (op == 3'd3) begin e.chk_res = 1; e.res = cdat; end
          q.push_back(e);
        end else begin
          e.done = 1; e.oc = 2'd0; q.push_back(e);
        end
      end
    end
    // drive
    @(negedge clk_i);
    op_i = op; cp_num_i = cpn; addr_i = addr; wb_i = wb; core_data_i = 32'h1357_9BDF;
    busy_n = nb; final_rsp = fin; inc_n = ni; cp_rdata_i = cdat;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (q.size() > 0) begin
      cmp(q.pop_front(), tag);
      @(negedge clk_i);
    end
    e = '{default: '0};
    cmp(e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_t z;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    z = '{default: '0};
    cmp(z, "R12");

    run("R12", 3'd4, 4'd1, 32'h0, 0, 0, 2'd0, 0, 32'h0);           // data op, accept at once
    cp_allow_i = 16'hFFFF & ~16'h0020;
    run("R1", 3'd0, 4'd5, 32'h100, 0, 0, 2'd0, 0, 32'h0);           // denied coprocessor
    run("R1", 3'd3, 4'd5, 32'h100, 0, 2, 2'd0, 0, 32'hABCD);
    cp_allow_i = 16'hFFFF;
    run("R2", 3'd0, 4'd2, 32'h0400_0000, 0, 0, 2'd0, 0, 32'h0);     // load out of range
    run("R2", 3'd1, 4'd2, 32'h0000_0010, 0, 0, 2'd0, 0, 32'h0);     // store into vectors
    run("R2", 3'd0, 4'd2, 32'h0000_0010, 0, 0, 2'd0, 0, 32'h0);     // load from vectors is fine
    run("R3", 3'd4, 4'd3, 32'h0, 0, 3, 2'd0, 0, 32'h0);             // busy wait
    irq_ni = 1'b0; irq_mask_i = 1'b1;
    run("R5", 3'd4, 4'd3, 32'h0, 0, 2, 2'd0, 0, 32'h0);             // masked irq ignored
    irq_mask_i = 1'b0;
    run("R4", 3'd4, 4'd3, 32'h0, 0, 2, 2'd0, 0, 32'h0);             // irq taken
    run("R4", 3'd4, 4'd3, 32'h0, 0, 0, 2'd0, 0, 32'h0);             // no wait, no effect
    fiq_ni = 1'b0;
    run("R5", 3'd2, 4'd3, 32'h0, 0, 1, 2'd0, 0, 32'h0);             // fiq beats irq
    reset_line_ni = 1'b0;
    run("R5", 3'd0, 4'd3, 32'h200, 0, 1, 2'd0, 0, 32'h0);           // reset beats all
    reset_line_ni = 1'b1; fiq_ni = 1'b1; irq_ni = 1'b1;
    run("R6", 3'd2, 4'd4, 32'h0, 0, 1, 2'd2, 0, 32'h0);             // refused move
    run("R6", 3'd0, 4'd4, 32'h300, 0, 0, 2'd2, 0, 32'h0);           // refused load
    run("R6", 3'd4, 4'd4, 32'h0, 0, 0, 2'd2, 0, 32'h0);             // refused data op
    run("R8", 3'd0, 4'd6, 32'h0000_1000, 1, 1, 2'd0, 3, 32'h0);     // load burst, writeback
    run("R7", 3'd1, 4'd6, 32'h0000_2000, 0, 0, 2'd0, 2, 32'hCAFE_F00D);
    run("R7", 3'd0, 4'd6, 32'h0000_3000, 0, 0, 2'd0, 0, 32'h0);
    abort_addr = 32'h0000_4004;
    run("R9", 3'd1, 4'd7, 32'h0000_4000, 1, 0, 2'd0, 3, 32'h1234_5678);
    abort_addr = 32'hFFFF_FFFF;
    run("R11", 3'd3, 4'd8, 32'h0, 0, 2, 2'd0, 0, 32'h8765_4321);    // move to core
    run("R11", 3'd2, 4'd8, 32'h0, 0, 0, 2'd0, 0, 32'h0);            // move to coprocessor
    run("R10", 3'd3, 4'd8, 32'h0, 0, 1, 2'd2, 0, 32'h8765_4321);    // refused move to core

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule